// File: doc/BRIEF.md
# Per-Bank Access Gap Timer

This block keeps a memory sequencer from starting a new access to a bank too soon after the previous one. When the control word being executed carries a start-timer flag, the sequencer pulses `start_strobe` and presents the bank index it is working on. The block stores that index and starts a short countdown. While the countdown runs, requests aimed at the stored bank are held off. Requests to any other bank pass straight through.

The countdown length comes from a 2-bit period selector. The selector is sampled only in the strobe cycle. If a strobe arrives while a countdown is still running, the count restarts and the stored bank is replaced. The grant output is combinational from the request bank and the registered timer state. A strobe therefore affects requests only from the cycle after it is sampled.

Top module: `bank_gap_timer`

## Requirements
- R1: The `period_sel` code sets the disable length N: code 0 gives 1 cycle, code 1 gives 2, code 2 gives 3 and code 3 gives 4.
- R2: After a clock edge that samples `start_strobe` high, `allow_same_bank` is low for exactly N consecutive cycles, then returns high unless another strobe was sampled in the meantime.
- R3: While `allow_same_bank` is low, `req_ok` is low whenever `req_bank` equals the stored bank.
- R4: `req_ok` is high whenever `req_bank` differs from the stored bank, whether or not the timer runs.
- R5: Once the countdown has expired, `req_ok` is high for the previously protected bank.
- R6: On a sampled strobe, `held_bank` takes the value of `start_bank`. Without a strobe, `held_bank` keeps its value.
- R7: A strobe sampled while the countdown runs reloads it with the newly selected N and replaces the stored bank. The old bank is released at once.
- R8: While `rst_n` is low and after its release, the timer is idle, `allow_same_bank` is high, `held_bank` is 0 and `req_ok` is high for every bank.
- R9: Changes to `period_sel` outside the strobe cycle do not alter a running countdown.
- R10: In the cycle in which `start_strobe` is high, `req_ok` still reflects the state from before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_sel | input | SEL_W (2) | Disable period code, sampled with the strobe |
| start_strobe | input | 1 | Start-timer flag from the executing control word |
| start_bank | input | BANK_W (3) | Bank being accessed when the strobe fires |
| req_bank | input | BANK_W (3) | Bank targeted by the next pending request |
| req_ok | output | 1 | High when a request to `req_bank` may start |
| allow_same_bank | output | 1 | High when the stored bank is not protected |
| held_bank | output | BANK_W (3) | Bank index currently stored by the timer |

## Verification
Two functions can fall into the same cycle: a running countdown can expire or be reloaded by a new strobe, and a request can be judged against the old stored bank while a strobe is capturing a new one. The bench fires strobes in back-to-back cycles and partway through a countdown, with a different period code and a different bank. It then counts the low cycles of `allow_same_bank` against the period of the last strobe, and checks that the earlier bank is released at once. In each strobe cycle, the bench also checks `req_ok` for the new bank against the state that held before the strobe.

// File: rtl/bank_gap_pkg.sv
package bank_gap_pkg;

   // Disable length in cycles for a period selector code.
   function automatic int unsigned gap_len(input int unsigned sel);
      return sel + 1;
   endfunction

   // Counter width able to hold the longest gap for a selector width.
   function automatic int unsigned gap_cnt_w(input int unsigned sel_w);
      return $clog2((1 << sel_w) + 1);
   endfunction

endpackage

// File: rtl/gap_period_decode.sv
module gap_period_decode #(
   parameter int SEL_W = 2,
   parameter int CNT_W = 3
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] len
);
   import bank_gap_pkg::*;

   localparam int NUM_CODES = 1 << SEL_W;

   generate
      if (gap_cnt_w(SEL_W) > CNT_W) begin : g_bad_width
         $error("gap_period_decode: CNT_W too small for SEL_W");
      end
   endgenerate

   always_comb begin
      len = '0;
      for (int c = 0; c < NUM_CODES; c++) begin
         if (sel == SEL_W'(c)) len = CNT_W'(gap_len(c));
      end
   end
endmodule

// File: rtl/gap_counter.sv
module gap_counter #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy
);
   logic [CNT_W-1:0] remain_q;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("gap_counter: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= load_val;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - CNT_W'(1);
      end
   end

   assign busy = (remain_q != '0);
endmodule

// File: rtl/bank_guard.sv
module bank_guard #(
   parameter int NUM_BANKS  = 8,
   parameter int BANK_W     = 3,
   parameter bit TAG_ONEHOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [BANK_W-1:0] cap_bank,
   input  logic [BANK_W-1:0] req_bank,
   output logic              match,
   output logic [BANK_W-1:0] held_bank
);
   generate
      if ((1 << BANK_W) < NUM_BANKS) begin : g_bad_width
         $error("bank_guard: BANK_W too narrow for NUM_BANKS");
      end

      if (TAG_ONEHOT) begin : g_mask
         // One flop per bank; the match is a single mux lookup.
         logic [NUM_BANKS-1:0] mask_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mask_q <= NUM_BANKS'(1);
            end else if (capture) begin
               for (int b = 0; b < NUM_BANKS; b++) begin
                  mask_q[b] <= (cap_bank == BANK_W'(b));
               end
            end
         end

         always_comb begin
            match     = 1'b0;
            held_bank = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
               if (mask_q[b] && req_bank == BANK_W'(b)) match = 1'b1;
               if (mask_q[b]) held_bank = BANK_W'(b);
            end
         end
      end else begin : g_index
         // Stored index and an equality compare.
         logic [BANK_W-1:0] tag_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tag_q <= '0;
            end else if (capture) begin
               tag_q <= cap_bank;
            end
         end

         assign match     = (req_bank == tag_q) && (req_bank < BANK_W'(NUM_BANKS - 1) + BANK_W'(1) || NUM_BANKS == (1 << BANK_W));
         assign held_bank = tag_q;
      end
   endgenerate
endmodule

// File: rtl/bank_gap_timer.sv
module bank_gap_timer #(
   parameter int NUM_BANKS  = 8,
   parameter int SEL_W      = 2,
   parameter bit TAG_ONEHOT = 1'b0,
   localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int CNT_W     = $clog2((1 << SEL_W) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  period_sel,
   input  logic              start_strobe,
   input  logic [BANK_W-1:0] start_bank,
   input  logic [BANK_W-1:0] req_bank,
   output logic              req_ok,
   output logic              allow_same_bank,
   output logic [BANK_W-1:0] held_bank
);
   generate
      if (NUM_BANKS < 2) begin : g_bad_banks
         $error("bank_gap_timer: NUM_BANKS must be at least 2");
      end
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("bank_gap_timer: SEL_W must be 1 to 4");
      end
   endgenerate

   logic [CNT_W-1:0] load_len;
   logic             busy;
   logic             bank_hit;

   gap_period_decode #(
      .SEL_W (SEL_W),
      .CNT_W (CNT_W)
   ) u_decode (
      .sel (period_sel),
      .len (load_len)
   );

   gap_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_strobe),
      .load_val (load_len),
      .busy     (busy)
   );

   bank_guard #(
      .NUM_BANKS  (NUM_BANKS),
      .BANK_W     (BANK_W),
      .TAG_ONEHOT (TAG_ONEHOT)
   ) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (start_strobe),
      .cap_bank  (start_bank),
      .req_bank  (req_bank),
      .match     (bank_hit),
      .held_bank (held_bank)
   );

   assign allow_same_bank = !busy;
   assign req_ok          = !(busy && bank_hit);
endmodule

// File: rtl/bank_gap_timer_chk.sv
module bank_gap_timer_chk #(
   parameter int BANK_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_strobe,
   input logic [BANK_W-1:0] start_bank,
   input logic [BANK_W-1:0] req_bank,
   input logic              req_ok,
   input logic              allow_same_bank,
   input logic [BANK_W-1:0] held_bank
);
   AST_STROBE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      start_strobe |=> !allow_same_bank); // R2

   AST_FALL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(allow_same_bank) |-> $past(start_strobe)); // R2

   AST_SAME_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!allow_same_bank && req_bank == held_bank) |-> !req_ok); // R3

   AST_OTHER_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_bank != held_bank) |-> req_ok); // R4

   AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      allow_same_bank |-> req_ok); // R5

   AST_BANK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      start_strobe |=> (held_bank == $past(start_bank))); // R6

   AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start_strobe |=> $stable(held_bank)); // R6

   AST_NO_RELEASE_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(allow_same_bank) |-> !$past(start_strobe)); // R7
endmodule

bind bank_gap_timer bank_gap_timer_chk #(.BANK_W(BANK_W)) u_chk (.*);

// File: tb/bank_gap_timer_tb.sv
`timescale 1ns/1ps
module bank_gap_timer_tb;
   localparam int NB = 8;
   localparam int BW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    period_sel = '0;
   logic          start_strobe = 1'b0;
   logic [BW-1:0] start_bank = '0;
   logic [BW-1:0] req_bank = '0;
   logic          req_ok;
   logic          allow_same_bank;
   logic [BW-1:0] held_bank;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   bank_gap_timer #(.NUM_BANKS(NB), .SEL_W(2)) u_dut (
      .clk, .rst_n, .period_sel, .start_strobe, .start_bank,
      .req_bank, .req_ok, .allow_same_bank, .held_bank
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic probe(input int bank, input int exp_ok, input string req);
      req_bank = BW'(bank);
      #0.5;
      chk(req_ok == exp_ok[0], req, req_ok, exp_ok);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Strobe with code sel on bank, then verify the whole window.
   task automatic run_window(input int sel, input int bank);
      int n;
      int other;
      n = sel + 1;  // R1
      other = (bank + 3) % NB;
      period_sel   = 2'(sel);
      start_strobe = 1'b1;
      start_bank   = BW'(bank);
      probe(bank, 1, "R10");
      step();
      start_strobe = 1'b0;
      for (int i = 0; i < n; i++) begin
         period_sel = 2'((sel + i + 1) % 4);  // R9 disturbance
         chk(allow_same_bank == 1'b0, "R1_R2 low", allow_same_bank, 0);
         chk(held_bank == BW'(bank), "R6", held_bank, bank);
         probe(bank, 0, "R3");
         probe(other, 1, "R4");
         if (i < n - 1) step();
      end
      step();
      chk(allow_same_bank == 1'b1, "R1_R2_R9 release", allow_same_bank, 1);
      probe(bank, 1, "R5");
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      int low;
      @(negedge clk);
      // R8: held in reset
      chk(allow_same_bank == 1'b1, "R8 reset allow", allow_same_bank, 1);
      for (int b = 0; b < NB; b++) probe(b, 1, "R8 reset req");
      step();
      rst_n = 1'b1;
      step();
      chk(held_bank == '0, "R8 held", held_bank, 0);
      chk(allow_same_bank == 1'b1, "R8 after", allow_same_bank, 1);

      // Sweep every code against every bank
      for (int s = 0; s < 4; s++)
         for (int b = 0; b < NB; b++) begin
            run_window(s, b);
            step();
         end

      // R7: restart mid-window with new bank and shorter code
      period_sel = 2'd3; start_bank = 3'd2; start_strobe = 1'b1;
      step();
      start_strobe = 1'b0;
      step();
      period_sel = 2'd1; start_bank = 3'd6; start_strobe = 1'b1;
      probe(6, 1, "R10 reload");
      probe(2, 0, "R10 old bank");
      step();
      start_strobe = 1'b0;
      probe(2, 1, "R7 old bank freed");
      chk(held_bank == 3'd6, "R7 held", held_bank, 6);
      low = 0;
      for (int i = 0; i < 8; i++) begin
         if (!allow_same_bank) low++;
         step();
      end
      chk(low == 2, "R7 reload length", low, 2);

      // R7: strobes in five back-to-back cycles with code 0
      period_sel = 2'd0;
      for (int i = 0; i < 5; i++) begin
         start_bank = BW'(i); start_strobe = 1'b1;
         step();
         chk(allow_same_bank == 1'b0, "R7 b2b low", allow_same_bank, 0);
         chk(held_bank == BW'(i), "R7 b2b held", held_bank, i);
      end
      start_strobe = 1'b0;
      step();
      chk(allow_same_bank == 1'b1, "R7 b2b release", allow_same_bank, 1);

      // R8: reset in the middle of a window
      period_sel = 2'd3; start_bank = 3'd5; start_strobe = 1'b1;
      step();
      start_strobe = 1'b0;
      rst_n = 1'b0;
      step();
      chk(allow_same_bank == 1'b1, "R8 mid reset", allow_same_bank, 1);
      chk(held_bank == '0, "R8 mid reset held", held_bank, 0);
      probe(5, 1, "R8 mid reset req");
      rst_n = 1'b1;
      step();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule